// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns a 32-bit address seen on the PCI side into a 34-bit system-memory address for DMA. Four programmable windows are checked together. Each window has a base, a size mask and a translated base. A window is used only when its enable bit is set, and the lowest-numbered enabled window that matches wins. A matching window either maps the address directly onto the translated base, or goes through a scatter-gather page table held in memory. In that case the block reads one 64-bit entry through its memory read port and joins the page frame in that entry with an 8 KB page offset. An address that no enabled window covers leaves the block unchanged.

Software sets up the windows through a simple register port. Each register is 64 bits wide and lives at a 64-byte stride. An access narrower than 64 bits is flagged and has no effect.

The translator is built around a three-state machine:
- `ST_IDLE` raises `req_ready`.
  - An accepted request for a direct hit, or for no hit, takes the transition `idle->resp`.
  - An accepted request for a scatter-gather hit takes `idle->fetch`.
- `ST_FETCH` holds `mem_req` until `mem_rvalid` arrives, then takes `fetch->resp`.
- `ST_RESP` pulses `res_valid` for one cycle and returns to idle through `resp->idle`.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset, every window register reads 0, the control register (index 12) reads 0x0000_0021_0010_0000 and `req_ready` is 1.
- R2: The register index is the byte offset shifted right by 6. Window i uses three indices: base at i, mask at 4+i and translated base at 8+i. The control register is at index 12. A full-width (size code 3) write to any of these indices is read back unchanged.
- R3: An access with `reg_size` other than 3 (codes 0/1/2 mean 1/2/4 bytes) raises `reg_err` and changes no register.
- R4: Index 13 (error status), index 14 (error mask) and index 15 (invalidate) accept writes without effect and read 0. Any index of 16 or above reads 0 and raises `reg_err`.
- R5: A window matches when the bus address and the base agree in every bit 31:20 whose mask bit is 0. Among enabled matching windows, the lowest index is used.
- R6: A window whose base bit 0 is 0 never matches. If no enabled window matches, the result is the bus address zero-extended.
- R7: Direct mode (base bit 1 = 0): let O = (mask & 0xFFF0_0000) | 0xF_FFFF. The result is (tbase & ~O) | (addr & O).
- R8: Scatter-gather mode (base bit 1 = 1) issues one read at (tbase & ~(((mask & 0xFFF0_0000) >> 10) | 0x3FF)) | ((addr & ((mask & 0xFFF0_0000) | 0xF_E000)) >> 10). `mem_req` and `mem_addr` stay steady until `mem_rvalid`.
- R9: In scatter-gather mode the result is ((entry with bit 0 cleared) << 12) | addr[12:0].
- R10: Every translated result and page-table address is cut to 34 bits.
- R11: A request is taken when `req_valid` and `req_ready` are both high. `res_valid` pulses for one cycle: the cycle after acceptance for direct or pass-through, and the cycle after `mem_rvalid` for scatter-gather. `req_ready` stays low from acceptance until the pulse has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 11 | Byte offset from block base |
| reg_size | input | 2 | Access size code (3 = 64-bit) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (combinational) |
| reg_err | output | 1 | Access-size or unmapped-index error |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_addr | input | 32 | PCI bus address |
| res_valid | output | 1 | One-cycle result strobe |
| res_addr | output | 34 | Translated DMA address |
| mem_req | output | 1 | Page-table read request, held until data |
| mem_addr | output | 34 | Page-table entry address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Page-table entry |

## Verification
Windows are set up at random with contiguous masks of 0 to 11 bits, random enable and mode bits, and random translated bases. Addresses are mostly drawn inside a chosen window and sometimes fully at random. This tells direct arithmetic apart from the scatter-gather entry address and frame merge, and a hit apart from pass-through. Directed cases separate the lowest-index priority from the skip of disabled windows. They also show the 34-bit truncation with a translated base whose upper bits are set, and a known page-table entry address. Memory latency is varied, so the wait in `ST_FETCH` and the blocking of new requests are both exercised.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int unsigned REG_W = 64;
    // bits of the mask register that take part in window matching
    localparam logic [63:0] WIN_SEL_MASK = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] DIR_OFF_MASK = 64'h0000_0000_000F_FFFF;
    localparam logic [63:0] SG_IDX_MASK  = 64'h0000_0000_000F_E000;
    localparam logic [63:0] SG_TB_LOW    = 64'h0000_0000_0000_03FF;
    localparam int unsigned PTE_SHIFT    = 10;
    localparam int unsigned PAGE_BITS    = 13;
    localparam int unsigned FRAME_SHIFT  = 12;
    localparam logic [63:0] CTRL_RESET   = 64'h0000_0021_0010_0000;

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] tbase;
    } win_cfg_t;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_RESP} xl_state_e;
endpackage

// File: rtl/xlate_regs.sv
module xlate_regs
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned REG_AW  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              reg_err,
    output win_cfg_t          cfg [NUM_WIN]
);
    localparam int unsigned IDX_W      = REG_AW - 6;
    localparam int unsigned IDX_CTRL   = 3 * NUM_WIN;
    localparam int unsigned IDX_LAST   = IDX_CTRL + 3;

    // R2: index = byte offset >> 6
    logic [IDX_W-1:0] idx;
    logic             full_sz;
    logic [REG_W-1:0] ctrl_q;
    logic             wr_ok;

    assign idx     = reg_addr[REG_AW-1:6];
    assign full_sz = (reg_size == 2'b11);
    assign wr_ok   = reg_en && reg_we && full_sz;

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= CTRL_RESET;
        else if (wr_ok && idx == IDX_W'(IDX_CTRL)) ctrl_q <= reg_wdata;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[w] <= '0;
            end else if (wr_ok) begin
                if (idx == IDX_W'(w))             cfg[w].base  <= reg_wdata;
                if (idx == IDX_W'(NUM_WIN + w))   cfg[w].mask  <= reg_wdata;
                if (idx == IDX_W'(2*NUM_WIN + w)) cfg[w].tbase <= reg_wdata;
            end
        end
    end

    // R3/R4: read path and error flag; status, mask and invalidate read 0
    always_comb begin
        reg_rdata = '0;
        reg_err   = reg_en && (!full_sz || (int'(idx) > IDX_LAST));
        if (reg_en && !reg_we && full_sz) begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if (idx == IDX_W'(w))             reg_rdata = cfg[w].base;
                if (idx == IDX_W'(NUM_WIN + w))   reg_rdata = cfg[w].mask;
                if (idx == IDX_W'(2*NUM_WIN + w)) reg_rdata = cfg[w].tbase;
            end
            if (idx == IDX_W'(IDX_CTRL)) reg_rdata = ctrl_q;
        end
    end

    assert_narrow_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && !full_sz) |-> reg_err);
    assert_narrow_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && reg_we && !full_sz) |=> $stable(ctrl_q));
endmodule

// File: rtl/xlate_match.sv
module xlate_match
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned BUS_AW  = 32,
    parameter int unsigned DMA_AW  = 34
) (
    input  win_cfg_t           cfg [NUM_WIN],
    input  logic [BUS_AW-1:0]  bus_addr,
    output logic               hit,
    output logic               sg,
    output logic [DMA_AW-1:0]  direct_addr,
    output logic [DMA_AW-1:0]  pte_addr
);
    localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    logic [NUM_WIN-1:0] win_hit;
    logic [SEL_W-1:0]   sel;
    logic [REG_W-1:0]   ext, m, off, tb, pte;

    assign ext = REG_W'(bus_addr);

    // R5/R6: per-window compare gated by the enable bit
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        assign win_hit[w] = cfg[w].base[0] &&
            (((ext ^ cfg[w].base) & ~cfg[w].mask & WIN_SEL_MASK) == '0);
    end

    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (win_hit[w]) begin
                hit = 1'b1;
                sel = SEL_W'(w);
            end
        end
    end

    // R7/R8/R10: address arithmetic for the chosen window
    always_comb begin
        m   = cfg[sel].mask & WIN_SEL_MASK;
        tb  = cfg[sel].tbase;
        sg  = hit && cfg[sel].base[1];
        off = m | DIR_OFF_MASK;
        pte = (tb & ~((m >> PTE_SHIFT) | SG_TB_LOW)) |
              ((ext & (m | SG_IDX_MASK)) >> PTE_SHIFT);
        direct_addr = hit ? DMA_AW'((tb & ~off) | (ext & off)) : DMA_AW'(ext);
        pte_addr    = DMA_AW'(pte);
    end
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
    import xlate_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned BUS_AW  = 32,
    parameter int unsigned DMA_AW  = 34,
    parameter int unsigned REG_AW  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_err,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUS_AW-1:0] req_addr,
    output logic              res_valid,
    output logic [DMA_AW-1:0] res_addr,
    output logic              mem_req,
    output logic [DMA_AW-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [63:0]       mem_rdata
);
    win_cfg_t            cfg [NUM_WIN];
    logic                hit, sg, accept;
    logic [DMA_AW-1:0]   direct_addr, pte_addr;
    xl_state_e           state_q, state_d;
    logic [DMA_AW-1:0]   res_q, memaddr_q;
    logic [PAGE_BITS-1:0] off_q;
    logic [63:0]         sg_full;

    xlate_regs #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) regs_i (
        .clk, .rst_n, .reg_en, .reg_we, .reg_addr, .reg_size,
        .reg_wdata, .reg_rdata, .reg_err, .cfg
    );

    xlate_match #(.NUM_WIN(NUM_WIN), .BUS_AW(BUS_AW), .DMA_AW(DMA_AW)) match_i (
        .cfg, .bus_addr(req_addr), .hit, .sg, .direct_addr, .pte_addr
    );

    assign accept  = req_valid && req_ready;
    // R9: frame from the entry (bit 0 cleared) merged with the 8 KB offset
    assign sg_full = ({mem_rdata[63:1], 1'b0} << FRAME_SHIFT) | 64'(off_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = sg ? ST_FETCH : ST_RESP;
            ST_FETCH: if (mem_rvalid) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q     <= '0;
            memaddr_q <= '0;
            off_q     <= '0;
        end else if (state_q == ST_IDLE && accept) begin
            res_q     <= direct_addr;
            memaddr_q <= pte_addr;
            off_q     <= req_addr[PAGE_BITS-1:0];
        end else if (state_q == ST_FETCH && mem_rvalid) begin
            res_q     <= DMA_AW'(sg_full);
        end
    end

    always_comb begin
        req_ready = 1'b0;
        mem_req   = 1'b0;
        res_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_FETCH: mem_req   = 1'b1;
            ST_RESP:  res_valid = 1'b1;
            default:  ;
        endcase
    end
    assign res_addr = res_q;
    assign mem_addr = memaddr_q;

    assert_fetch_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (res_valid || mem_req));
    assert_mem_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/dma_window_xlate_tb_top.sv
module dma_window_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 0, reg_we = 0;
    logic [10:0] reg_addr = '0;
    logic [1:0]  reg_size = 2'b11;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic        reg_err;
    logic        req_valid = 0, req_ready;
    logic [31:0] req_addr = '0;
    logic        res_valid, mem_req;
    logic [33:0] res_addr, mem_addr;
    logic        mem_rvalid = 0;
    logic [63:0] mem_rdata = '0;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [63:0] wb [4], wm [4], wt [4];

    always #10 clk = ~clk;

    dma_window_xlate dut_i (.*);

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pte_data(logic [33:0] a);
        return {a[31:0] ^ 32'hA5C3_1E07, a[31:0] ^ 32'h0000_5A5B};
    endfunction

    // reference model from the requirements
    function automatic void ref_xl(input logic [31:0] a, output bit is_sg,
                                   output logic [33:0] res, output logic [33:0] pa);
        logic [63:0] e, m, o;
        is_sg = 0; res = {2'b0, a}; pa = '0;
        e = {32'b0, a};
        for (int i = 0; i < 4; i++) begin
            if (wb[i][0] && (((e ^ wb[i]) & ~wm[i] & 64'hFFF0_0000) == 0)) begin
                m = wm[i] & 64'hFFF0_0000;
                if (wb[i][1]) begin
                    is_sg = 1;
                    o = (wt[i] & ~((m >> 10) | 64'h3FF)) | ((e & (m | 64'hF_E000)) >> 10);
                    pa = o[33:0];
                    o = ((pte_data(pa) & ~64'h1) << 12) | {51'b0, a[12:0]};
                    res = o[33:0];
                end else begin
                    o = m | 64'hF_FFFF;
                    o = (wt[i] & ~o) | (e & o);
                    res = o[33:0];
                end
                return;
            end
        end
    endfunction

    task automatic reg_wr(int idx, logic [63:0] d, logic [1:0] sz = 2'b11);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = 11'(idx << 6); reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0; reg_size = 2'b11;
    endtask

    task automatic reg_rd(int idx, output logic [63:0] d, output logic e);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = 11'(idx << 6); reg_size = 2'b11;
        #2; d = reg_rdata; e = reg_err;
        reg_en = 0;
    endtask

    task automatic set_win(int i, logic [63:0] b, logic [63:0] m, logic [63:0] t);
        wb[i] = b; wm[i] = m; wt[i] = t;
        reg_wr(i, b); reg_wr(4 + i, m); reg_wr(8 + i, t);
    endtask

    task automatic xl(logic [31:0] a, string tag);
        bit is_sg, fetched = 0, seen = 0;
        logic [33:0] er, ep, got = '0;
        ref_xl(a, is_sg, er, ep);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(posedge clk); #1 req_valid = 0;
        for (int t = 0; t < 60 && !seen; t++) begin
            @(negedge clk);
            if (res_valid) begin
                got = res_addr; seen = 1;
            end else if (mem_req) begin
                fetched = 1;
                chk("R11 ready low during fetch", {63'b0, req_ready}, 64'd0);
                chk({"R8 entry address ", tag}, {30'b0, mem_addr}, {30'b0, ep});
                repeat ($urandom_range(0, 4)) @(negedge clk);
                mem_rvalid = 1; mem_rdata = pte_data(mem_addr);
                @(posedge clk); #1 mem_rvalid = 0;
            end
        end
        chk({"R11 result seen ", tag}, {63'b0, seen}, 64'd1);
        chk({"R8 fetch iff sg ", tag}, {63'b0, fetched}, {63'b0, is_sg});
        chk({"R5 R7 R9 R10 result ", tag}, {30'b0, got}, {30'b0, er});
        @(negedge clk);
        chk("R11 pulse ended", {63'b0, res_valid}, 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        chk("watchdog", 64'd1, 64'd0);
        if (!finished) begin
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] d; logic e;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin wb[i] = 0; wm[i] = 0; wt[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1
        reg_rd(12, d, e); chk("R1 control reset", d, 64'h0000_0021_0010_0000);
        reg_rd(0, d, e);  chk("R1 base reset", d, 64'd0);
        chk("R1 ready", {63'b0, req_ready}, 64'd1);
        // R2
        reg_wr(9, 64'hDEAD_BEEF_0123_4567); reg_rd(9, d, e);
        chk("R2 tbase1 readback", d, 64'hDEAD_BEEF_0123_4567);
        reg_wr(12, 64'h1234_0000_0000_00FF); reg_rd(12, d, e);
        chk("R2 control readback", d, 64'h1234_0000_0000_00FF);
        // R3
        @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = 11'(12 << 6); reg_size = 2'b10;
        reg_wdata = 64'h5; #2 chk("R3 narrow err", {63'b0, reg_err}, 64'd1);
        @(negedge clk); reg_en = 0; reg_size = 2'b11;
        reg_rd(12, d, e); chk("R3 narrow write ignored", d, 64'h1234_0000_0000_00FF);
        // R4
        for (int k = 13; k <= 15; k++) begin
            reg_wr(k, 64'hFFFF_FFFF_FFFF_FFFF); reg_rd(k, d, e);
            chk("R4 status/inval read zero", d, 64'd0);
            chk("R4 no err", {63'b0, e}, 64'd0);
        end
        reg_rd(16, d, e); chk("R4 unmapped err", {63'b0, e}, 64'd1);
        chk("R4 unmapped zero", d, 64'd0);
        // R6 pass-through with nothing enabled
        set_win(1, 0, 0, 0);
        xl(32'h8765_4321, "R6 passthrough");
        // R5 priority and R6 disabled skip
        set_win(0, 64'h4000_0001, 64'h00F0_0000, 64'h1_0000_0000);
        set_win(1, 64'h4000_0001, 64'h0FF0_0000, 64'h2_0000_0000);
        xl(32'h4012_3456, "R5 lowest wins");
        set_win(0, 64'h4000_0000, 64'h00F0_0000, 64'h1_0000_0000);
        xl(32'h4012_3456, "R6 disabled skipped");
        // R10 truncation
        set_win(0, 64'h4000_0001, 64'h0, 64'hFFFF_FFFF_0000_0000);
        xl(32'h4001_2345, "R10 trunc");
        chk("R10 direct value", {30'b0, res_addr}, 64'h3_0001_2345);
        // R8/R9 known entry address
        set_win(2, 64'h8000_0003, 64'h0010_0000, 64'h1_2345_6000);
        xl(32'h801F_E123, "R9 sg directed");
        // random
        for (int n = 0; n < 150; n++) begin
            if (n % 30 == 0) begin
                for (int i = 0; i < 4; i++) begin
                    int k = $urandom_range(0, 11);
                    logic [63:0] m = ((64'd1 << k) - 1) << 20;
                    logic [63:0] b = {$urandom, $urandom};
                    b[1:0] = {1'($urandom), 1'($urandom_range(0, 3) != 0)};
                    set_win(i, b, m, {$urandom, $urandom});
                end
            end
            begin
                logic [31:0] a = $urandom;
                int w = $urandom_range(0, 3);
                if ($urandom_range(0, 3) != 0)
                    a[31:20] = (wb[w][31:20] & ~wm[w][31:20]) | (a[31:20] & wm[w][31:20]);
                xl(a, "random");
            end
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule